// File: doc/BRIEF.md
# Dual-Core Low-Power Status Flag Register

This block is one 32-bit status word that tells software which low-power states the system has gone through. It keeps a separate record for each of two processor cores. For each core, pulse inputs from the power sequencer set three sticky flags: Stop 0/1 entry, Stop 2 entry and Standby entry. Each flag stays at 1 until software clears it or a reset of the right kind arrives. The word also carries two live bits that follow whether each core is in Deep-Sleep at this moment. The live bit of core 2 also reads 1 while that core is held at boot.

The flags sit in two reset domains. The Standby flags are kept through a system reset and are lost only on power-on reset. The Stop flags are cleared by either kind of reset. Software clears flags by writing the word with a one in the clear bit of a core. That strobe clears the core's Stop 0/1 and Standby flags and leaves its Stop 2 flag alone. The read port is combinational and shows the current word. The write port is a plain enable plus data. It is a control path with no back-pressure, so it has no valid/ready handshake.

Top module: `lpf_status_reg`

## Requirements
- R1: While `por_n` is low, every bit of `rd_data` reads 0, except that bits 15 and 14 still follow their live inputs.
- R2: A cycle with `ev_stop01[k]` high sets the Stop 0/1 flag of core k+1 (bit 10 for core 1, bit 13 for core 2). A cycle with `ev_stop2[k]` high sets the Stop 2 flag (bit 9 for core 1, bit 12 for core 2). Each flag reads 1 from the clock edge that samples the event.
- R3: A cycle with `ev_stby[k]` high sets the Standby flag (bit 8 for core 1, bit 11 for core 2). The flag stays 1 while no clear and no power-on reset occurs.
- R4: A write with `wr_data[0]`=1 clears bits 10 and 8, and a write with `wr_data[1]`=1 clears bits 13 and 11. The Stop 2 flags (bits 9 and 12) are not changed by either strobe.
- R5: If a set event and a clear strobe for the same flag arrive in the same cycle, the flag reads 1 after that edge.
- R6: A system reset (`sys_rst_n` low, `por_n` high) clears bits 13, 12, 10 and 9 and leaves bits 11 and 8 unchanged.
- R7: Bit 14 equals `deep_sleep[0]`. Bit 15 equals `deep_sleep[1]` OR `boot_hold`. Both bits follow their inputs combinationally.
- R8: Bits 31:16 and 7:0 always read 0. Writes to bits 15:8 have no effect. A write of 0 to bits 1:0 has no effect.
- R9: A power-on reset clears all six sticky flags, including the Standby flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous; resets both domains |
| sys_rst_n | input | 1 | Active-low system reset, asynchronous; resets the Stop flags only |
| ev_stop01 | input | 2 | Per-core Stop 0/1 entry event (bit 0 = core 1) |
| ev_stop2 | input | 2 | Per-core Stop 2 entry event |
| ev_stby | input | 2 | Per-core Standby entry event |
| deep_sleep | input | 2 | Live per-core Deep-Sleep indicator |
| boot_hold | input | 1 | Core 2 is held at boot |
| wr_en | input | 1 | Register write enable |
| wr_data | input | 32 | Write data; only bits 1:0 act |
| rd_data | output | 32 | Current status word |

## Verification
The bench checks the per-domain reset split. A design that clears Standby on a system reset, or that keeps a Stop flag through one, shows a wrong bit 8 or 11, or a wrong bit 9, 10, 12 or 13. It checks that a clear strobe leaves the Stop 2 flag of the core untouched and does not reach the other core's flags. It checks that a set event in the same cycle as a clear wins. It checks that writes to the status bits, and writes of zero to the strobes, change nothing. Randomly mixed events, strobes and resets are compared each cycle against a model word built in the bench.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
  localparam int unsigned DATA_W        = 32;
  localparam int unsigned NUM_CORES     = 2;
  localparam int unsigned FLAG_LSB      = 8;
  localparam int unsigned FLAGS_PER_CORE = 3;
  localparam int unsigned DS_LSB        = FLAG_LSB + NUM_CORES * FLAGS_PER_CORE;
  localparam int unsigned CLR_LSB       = 0;
  // Offsets of each flag inside one core's group
  localparam int unsigned OFS_STBY   = 0;
  localparam int unsigned OFS_STOP2  = 1;
  localparam int unsigned OFS_STOP01 = 2;

  typedef struct packed {
    logic stop01;
    logic stop2;
    logic stby;
  } core_flags_t;
endpackage

// File: rtl/lpf_sticky_bit.sv
module lpf_sticky_bit #(
  parameter bit CLR_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic clr_eff;

  generate
    if (CLR_EN) begin : g_clr
      assign clr_eff = clr_i;
    end else begin : g_noclr
      assign clr_eff = 1'b0;
    end
  endgenerate

  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= 1'b0;
    else if (set_i)   q_o <= 1'b1;
    else if (clr_eff) q_o <= 1'b0;
  end
endmodule

// File: rtl/lpf_core_bank.sv
module lpf_core_bank
  import lpf_pkg::*;
(
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_dom_n,
  input  logic        ev_stop01,
  input  logic        ev_stop2,
  input  logic        ev_stby,
  input  logic        clr_strobe,
  output core_flags_t flags_o
);
  logic q_stop01, q_stop2, q_stby;

  // Stop 0/1: system domain, cleared by strobe
  lpf_sticky_bit #(.CLR_EN(1'b1)) u_stop01 (
    .clk(clk), .rst_n(sys_dom_n), .set_i(ev_stop01), .clr_i(clr_strobe), .q_o(q_stop01));

  // Stop 2: system domain, strobe has no effect
  lpf_sticky_bit #(.CLR_EN(1'b0)) u_stop2 (
    .clk(clk), .rst_n(sys_dom_n), .set_i(ev_stop2), .clr_i(clr_strobe), .q_o(q_stop2));

  // Standby: power-on domain only, cleared by strobe
  lpf_sticky_bit #(.CLR_EN(1'b1)) u_stby (
    .clk(clk), .rst_n(por_n), .set_i(ev_stby), .clr_i(clr_strobe), .q_o(q_stby));

  always_comb begin
    flags_o.stop01 = q_stop01;
    flags_o.stop2  = q_stop2;
    flags_o.stby   = q_stby;
  end
endmodule

// File: rtl/lpf_word_pack.sv
module lpf_word_pack
  import lpf_pkg::*;
#(
  parameter int unsigned N_CORES = NUM_CORES,
  parameter logic [N_CORES-1:0] HOLD_MASK = 2'b10
) (
  input  core_flags_t [N_CORES-1:0] flags_i,
  input  logic [N_CORES-1:0]        deep_sleep,
  input  logic                      boot_hold,
  output logic [DATA_W-1:0]         word_o
);
  always_comb begin
    word_o = '0;
    for (int k = 0; k < int'(N_CORES); k++) begin
      word_o[FLAG_LSB + k*FLAGS_PER_CORE + OFS_STBY]   = flags_i[k].stby;
      word_o[FLAG_LSB + k*FLAGS_PER_CORE + OFS_STOP2]  = flags_i[k].stop2;
      word_o[FLAG_LSB + k*FLAGS_PER_CORE + OFS_STOP01] = flags_i[k].stop01;
      word_o[DS_LSB + k] = deep_sleep[k] | (HOLD_MASK[k] & boot_hold);
    end
  end
endmodule

// File: rtl/lpf_status_reg.sv
module lpf_status_reg
  import lpf_pkg::*;
(
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 sys_rst_n,
  input  logic [NUM_CORES-1:0] ev_stop01,
  input  logic [NUM_CORES-1:0] ev_stop2,
  input  logic [NUM_CORES-1:0] ev_stby,
  input  logic [NUM_CORES-1:0] deep_sleep,
  input  logic                 boot_hold,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data
);
  logic sys_dom_n;
  logic [NUM_CORES-1:0] clr_strobe;
  core_flags_t [NUM_CORES-1:0] flags;

  // power-on reset also resets the system domain
  assign sys_dom_n  = por_n & sys_rst_n;
  assign clr_strobe = wr_en ? wr_data[CLR_LSB +: NUM_CORES] : '0;

  generate
    for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
      lpf_core_bank u_bank (
        .clk(clk), .por_n(por_n), .sys_dom_n(sys_dom_n),
        .ev_stop01(ev_stop01[k]), .ev_stop2(ev_stop2[k]), .ev_stby(ev_stby[k]),
        .clr_strobe(clr_strobe[k]), .flags_o(flags[k]));
    end
  endgenerate

  lpf_word_pack #(.N_CORES(NUM_CORES), .HOLD_MASK(2'b10)) u_pack (
    .flags_i(flags), .deep_sleep(deep_sleep), .boot_hold(boot_hold), .word_o(rd_data));
endmodule

// File: rtl/lpf_status_chk.sv
module lpf_status_chk
  import lpf_pkg::*;
(
  input logic                 clk,
  input logic                 por_n,
  input logic                 sys_rst_n,
  input logic [NUM_CORES-1:0] ev_stop01,
  input logic [NUM_CORES-1:0] ev_stop2,
  input logic [NUM_CORES-1:0] ev_stby,
  input logic [NUM_CORES-1:0] deep_sleep,
  input logic                 boot_hold,
  input logic                 wr_en,
  input logic [DATA_W-1:0]    wr_data,
  input logic [DATA_W-1:0]    rd_data
);
  p_stop01_set_r2: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    ev_stop01[0] |=> rd_data[10]);
  p_stby_set_r3: assert property (@(posedge clk) disable iff (!por_n)
    ev_stby[1] |=> rd_data[11]);
  p_stop2_keep_r4: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    rd_data[12] |=> rd_data[12]);
  p_clear_r4: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (wr_en && wr_data[0] && !ev_stop01[0]) |=> !rd_data[10]);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_data[0] && ev_stby[0]) |=> rd_data[8]);
  p_stby_keep_r6: assert property (@(posedge clk) disable iff (!por_n)
    (rd_data[8] && !(wr_en && wr_data[0])) |=> rd_data[8]);
  p_ds_live_r7: assert property (@(posedge clk) disable iff (!por_n)
    (rd_data[15] == (deep_sleep[1] | boot_hold)) && (rd_data[14] == deep_sleep[0]));
  p_reserved_r8: assert property (@(posedge clk) disable iff (!por_n)
    (rd_data[31:16] == 16'h0) && (rd_data[7:0] == 8'h0));
endmodule

bind lpf_status_reg lpf_status_chk chk_i (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .ev_stop01(ev_stop01),
  .ev_stop2(ev_stop2), .ev_stby(ev_stby), .deep_sleep(deep_sleep),
  .boot_hold(boot_hold), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

// File: tb/lpf_status_reg_tb_top.sv
module lpf_status_reg_tb_top;
  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b1;
  logic [1:0] ev01 = '0, ev2 = '0, evsb = '0, ds = '0;
  logic hold = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [1:0] m01 = '0, m2 = '0, msb = '0;

  always #4 clk = ~clk;

  lpf_status_reg dut_i (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .ev_stop01(ev01), .ev_stop2(ev2),
    .ev_stby(evsb), .deep_sleep(ds), .boot_hold(hold), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data));

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    for (int k = 0; k < 2; k++) begin
      w[8 + 3*k]  = msb[k];
      w[9 + 3*k]  = m2[k];
      w[10 + 3*k] = m01[k];
    end
    w[14] = ds[0];
    w[15] = ds[1] | hold;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // apply current inputs for one edge, update model, check at negedge
  task automatic step(input string req);
    logic [1:0] clr;
    @(posedge clk);
    clr = wr_en ? wr_data[1:0] : 2'b00;
    if (!por_n) begin
      m01 = '0; m2 = '0; msb = '0;
    end else begin
      msb = evsb | (msb & ~clr);
      if (!sys_rst_n) begin
        m01 = '0; m2 = '0;
      end else begin
        m01 = ev01 | (m01 & ~clr);
        m2  = ev2 | m2;
      end
    end
    @(negedge clk);
    check(req, rd_data, exp_word());
  endtask

  task automatic idle();
    ev01 = '0; ev2 = '0; evsb = '0; wr_en = 0; wr_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234_5678));
    @(negedge clk);
    ev01 = 2'b11; ev2 = 2'b11; evsb = 2'b11; ds = 2'b01;
    step("R1"); step("R1");
    check("R1 flags zero in POR", rd_data & 32'h0000_3fff, 32'h0);
    por_n = 1; idle(); step("R1");
    // R2 set stop flags
    ev01 = 2'b01; ev2 = 2'b10; step("R2");
    check("R2 bit10", {31'h0, rd_data[10]}, 32'h1);
    check("R2 bit12", {31'h0, rd_data[12]}, 32'h1);
    idle(); ev01 = 2'b10; ev2 = 2'b01; step("R2");
    // R3 standby
    idle(); evsb = 2'b11; step("R3"); idle(); step("R3");
    check("R3 bits 11,8", {30'h0, rd_data[11], rd_data[8]}, 32'h3);
    // R4 clear core1
    wr_en = 1; wr_data = 32'h1; step("R4");
    check("R4 bit9 kept", {31'h0, rd_data[9]}, 32'h1);
    check("R4 core1 cleared", {30'h0, rd_data[10], rd_data[8]}, 32'h0);
    idle(); wr_en = 1; wr_data = 32'h2; step("R4");
    check("R4 bit12 kept", {31'h0, rd_data[12]}, 32'h1);
    // R5 set wins
    idle(); wr_en = 1; wr_data = 32'h3; ev01 = 2'b10; evsb = 2'b01; step("R5");
    check("R5 bit13", {31'h0, rd_data[13]}, 32'h1);
    check("R5 bit8", {31'h0, rd_data[8]}, 32'h1);
    // R8 ignored writes
    idle(); evsb = 2'b10; ev01 = 2'b01; step("R8"); idle();
    wr_en = 1; wr_data = 32'hffff_fffc; step("R8");
    check("R8 reserved and strobes", rd_data & 32'hffff_00ff, 32'h0);
    check("R8 flags unchanged", {26'h0, rd_data[13:8]}, 32'h3f);
    // R6 system reset
    idle(); sys_rst_n = 0; step("R6");
    check("R6 stop cleared sb kept", {26'h0, rd_data[13:8]}, 32'h09);
    sys_rst_n = 1; step("R6");
    // R7 live bits
    ds = 2'b00; hold = 1; step("R7");
    check("R7 bit15 hold", {30'h0, rd_data[15:14]}, 32'h2);
    ds = 2'b01; hold = 0; step("R7");
    check("R7 bit14", {30'h0, rd_data[15:14]}, 32'h1);
    // R9 POR clears standby
    ev01 = 2'b11; step("R9"); idle(); por_n = 0; step("R9");
    check("R9 all flags", {26'h0, rd_data[13:8]}, 32'h0);
    por_n = 1; step("R9");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      ev01 = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      ev2  = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      evsb = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      ds = 2'($urandom); hold = 1'($urandom);
      wr_en = ($urandom % 4 == 0); wr_data = $urandom;
      sys_rst_n = ($urandom % 40 != 0);
      por_n = ($urandom % 150 != 0);
      step("random R2 R3 R4 R5 R6 R8 R9");
    end
    finish_run();
  end
endmodule